// File: doc/BRIEF.md
# RTC Interrupt Status and Periodic Tick Unit

This unit collects every interrupt source of a real-time clock and drives one level-sensitive interrupt line. A free-running divider runs on a 1024 Hz enable input. From this divider the unit derives a 1 Hz tick and nine binary sampling rates from 2 Hz to 512 Hz. Alarm-match and stopwatch events come from outside as one-cycle pulses.

Each event sets its own bit in a 16-bit status register. A bit is set whether or not the event is enabled, so software can poll a source that it has masked. The interrupt output is high while any status bit that is set also has its bit set in the enable register.

Software writes the status register with ones to acknowledge events. A zero in the written word leaves the matching bit alone. The enable register is written directly. Both registers are visible at the ports.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, the status word and the enable word are all zero and irq_o is low.
- R2: The status bits for the sampling rates are fixed. 2 Hz is bit 7. The rates 4, 8, 16, 32, 64, 128, 256 and 512 Hz are bits 8 to 15 in that order. A rate of 2^k Hz sets its bit on the tick at which the tick count since reset reaches a multiple of 1024/2^k.
- R3: Bit 4 (1 Hz) is set on every 1024th tick. Whenever a slower rate fires, every faster rate fires in the same cycle.
- R4: An alarm_i pulse sets bit 2. A stopwatch_i pulse sets bit 0. The bit is visible in the cycle after the pulse.
- R5: A write with wsel_i=0 clears each status bit whose wdata_i bit is 1 and leaves every other bit unchanged. Writing 16'hFFFF clears all bits.
- R6: If an event and a clear of its bit happen in the same cycle, the bit stays set.
- R7: A write with wsel_i=1 loads the enable word from wdata_i, restricted to the implemented bits (mask 16'hFF95).
- R8: irq_o is high exactly when status_o AND enable_o is nonzero. It follows register changes in the same cycle.
- R9: A status bit is set whatever the state of its enable bit, and it holds until it is cleared.
- R10: Bits 1, 3, 5 and 6 of both registers always read zero, and writes to them have no effect.
- R11: The divider advances only in cycles where tick_1024_i is high. No rate bit is set in a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1024_i | input | 1 | 1024 Hz enable, one cycle wide |
| alarm_i | input | 1 | Alarm-match pulse |
| stopwatch_i | input | 1 | Stopwatch expiry pulse |
| wr_i | input | 1 | Register write strobe |
| wsel_i | input | 1 | Write target: 0 = status (write ones to clear), 1 = enable |
| wdata_i | input | 16 | Write data |
| status_o | output | 16 | Status register |
| enable_o | output | 16 | Enable register |
| irq_o | output | 1 | Level interrupt |

## Verification
Suppose the divider count is off by even one tick. The error shows as a wrong rate bit in status_o. At the latest it appears on the next 512 Hz event, two ticks later. Slip in the slow bits only surfaces when they come due, so the bench runs more than 1024 ticks in a row. A status or enable bit that is wrongly held or wrongly cleared changes status_o or irq_o in the very next cycle. For that reason the bench compares every register and the interrupt line after each clock edge.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int STAT_W  = 16;
  localparam int DIV_W   = 10;
  localparam int SW_BIT  = 0;
  localparam int ALM_BIT = 2;
  localparam int HZ1_BIT = 4;
  localparam int HZ2_BIT = 7;
  localparam int FAST_LSB = 8;
  localparam logic [STAT_W-1:0] IMPL_MASK = 16'hFF95;

  // status position of the 2^k Hz rate
  function automatic int rate_pos(input int k);
    if (k == 0) return HZ1_BIT;
    if (k == 1) return HZ2_BIT;
    return FAST_LSB + k - 2;
  endfunction
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [DIV_W-1:0] rate_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nx;
  assign cnt_nx = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nx;
  end

  // rate_o[k] is the 2^k Hz event
  for (genvar k = 0; k < DIV_W; k++) begin : g_rate
    assign rate_o[k] = tick_i && (cnt_nx[DIV_W-1-k:0] == '0);
  end

  for (genvar k = 1; k < DIV_W; k++) begin : g_chk
    assert_slow_implies_fast_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rate_o[k-1] |-> rate_o[k]);
  end

  assert_hold_without_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_no_rate_without_tick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> rate_o == '0);
endmodule

// File: rtl/rtc_evt_map.sv
module rtc_evt_map
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W  = rtc_irq_pkg::DIV_W,
  parameter int STAT_W = rtc_irq_pkg::STAT_W
) (
  input  logic [DIV_W-1:0]  rate_i,
  input  logic              alarm_i,
  input  logic              stopwatch_i,
  output logic [STAT_W-1:0] evt_o
);
  logic [DIV_W-1:0][STAT_W-1:0] part;

  for (genvar k = 0; k < DIV_W; k++) begin : g_map
    assign part[k] = STAT_W'(rate_i[k]) << rate_pos(k);
  end

  always_comb begin
    evt_o = '0;
    for (int k = 0; k < DIV_W; k++) evt_o |= part[k];
    evt_o[ALM_BIT] = alarm_i;
    evt_o[SW_BIT]  = stopwatch_i;
  end
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int STAT_W = rtc_irq_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              wr_i,
  input  logic              wsel_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o
);
  logic [STAT_W-1:0] clr, stat_nx;

  assign clr     = (wr_i && !wsel_i) ? wdata_i : '0;
  assign stat_nx = ((status_o & ~clr) | evt_i) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      enable_o <= '0;
    end else begin
      status_o <= stat_nx;
      if (wr_i && wsel_i) enable_o <= wdata_i & IMPL_MASK;
    end
  end

  assert_alarm_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[ALM_BIT] |=> status_o[ALM_BIT]);
  assert_w1c_alarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wsel_i && wdata_i[ALM_BIT] && !evt_i[ALM_BIT] |=> !status_o[ALM_BIT]);
  assert_event_beats_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[ALM_BIT] && wr_i && !wsel_i && wdata_i[ALM_BIT] |=> status_o[ALM_BIT]);
  assert_pending_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ALM_BIT] && !(wr_i && !wsel_i && wdata_i[ALM_BIT]) |=> status_o[ALM_BIT]);
  assert_unused_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o | enable_o) & ~IMPL_MASK) == '0);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_1024_i,
  input  logic              alarm_i,
  input  logic              stopwatch_i,
  input  logic              wr_i,
  input  logic              wsel_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DIV_W-1:0]  rate;
  logic [STAT_W-1:0] evt;

  rtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_1024_i),
    .rate_o(rate)
  );

  rtc_evt_map #(.DIV_W(DIV_W), .STAT_W(STAT_W)) u_map (
    .rate_i     (rate),
    .alarm_i    (alarm_i),
    .stopwatch_i(stopwatch_i),
    .evt_o      (evt)
  );

  rtc_irq_regs #(.STAT_W(STAT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .wr_i    (wr_i),
    .wsel_i  (wsel_i),
    .wdata_i (wdata_i),
    .status_o(status_o),
    .enable_o(enable_o)
  );

  assign irq_o = |(status_o & enable_o);

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o == '0) |-> !irq_o);
  assert_irq_on_pending_alarm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ALM_BIT] && enable_o[ALM_BIT] |-> irq_o);
endmodule

// File: tb/rtc_irq_unit_tb.sv
module rtc_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, alm = 1'b0, sw = 1'b0, wr = 1'b0, wsel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] status, enable;
  logic        irq;

  int checks = 0, errors = 0;
  int          m_cnt = 0;
  logic [15:0] m_stat = '0, m_en = '0;
  localparam logic [15:0] MASK = 16'hFF95;

  always #2 clk = ~clk;

  rtc_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1024_i(tick), .alarm_i(alm),
    .stopwatch_i(sw), .wr_i(wr), .wsel_i(wsel), .wdata_i(wdata),
    .status_o(status), .enable_o(enable), .irq_o(irq)
  );

  function automatic logic [15:0] rate_ev(input int n);
    logic [15:0] v = '0;
    for (int k = 0; k < 10; k++) begin
      if (n % (1024 >> k) == 0) begin
        if (k == 0)      v[4] = 1'b1;
        else if (k == 1) v[7] = 1'b1;
        else             v[6 + k] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic a, input logic s, input logic w,
                     input logic sel, input logic [15:0] d, input string tag);
    logic [15:0] ev;
    @(negedge clk);
    tick = t; alm = a; sw = s; wr = w; wsel = sel; wdata = d;
    ev = '0;
    if (t) begin
      m_cnt = (m_cnt + 1) % 1024;
      ev = rate_ev(m_cnt);
    end
    ev[2] = ev[2] | a;
    ev[0] = ev[0] | s;
    if (w && !sel) m_stat = m_stat & ~d;
    m_stat = (m_stat | ev) & MASK;
    if (w && sel) m_en = d & MASK;
    @(posedge clk); #1;
    check({tag, " status"}, status, m_stat);
    check("R7 R10 enable", enable, m_en);
    check("R8 irq", {15'd0, irq}, {15'd0, |(m_stat & m_en)});
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act timeout exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    #9;
    check("R1 status", status, 16'h0);
    check("R1 enable", enable, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: first ticks, 512 and 256 Hz pattern
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, 0, 16'h0, "R2");
    // R11: no tick, nothing changes after clearing
    cyc(0, 0, 0, 1, 0, 16'hFFFF, "R5");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 16'h0, "R11");
    // R3: run through a full second of ticks
    for (int i = 0; i < 1030; i++) cyc(1, 0, 0, 0, 0, 16'h0, "R3");
    cyc(0, 0, 0, 1, 0, 16'hFFFF, "R5");
    // R4 / R9: events latched with enable clear
    cyc(0, 1, 0, 0, 0, 16'h0, "R4 R9");
    cyc(0, 0, 1, 0, 0, 16'h0, "R4 R9");
    cyc(0, 0, 0, 0, 0, 16'h0, "R9");
    // R5: write zeros keeps, single bit clears
    cyc(0, 0, 0, 1, 0, 16'h0000, "R5");
    cyc(0, 0, 0, 1, 0, 16'h0001, "R5");
    // R8: enable alarm raises irq
    cyc(0, 0, 0, 1, 1, 16'h0004, "R8");
    // R6: event with same-cycle clear
    cyc(0, 1, 0, 1, 0, 16'h0004, "R6");
    cyc(0, 0, 0, 1, 0, 16'h0004, "R5");
    // R10: unused bits ignored
    cyc(0, 0, 0, 1, 1, 16'hFFFF, "R10");
    cyc(0, 0, 0, 1, 0, 16'h006A, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 2) == 0, ($urandom % 16) == 0, ($urandom % 16) == 0,
          ($urandom % 4) == 0, ($urandom % 3) == 0, 16'($urandom), "R2 R4 R5 R6");
    end
    cyc(0, 0, 0, 0, 0, 16'h0, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule